// File: doc/BRIEF.md
# Pattern-Driven Multicast Receiver Chain

This block decides which elements of a linear array of processing elements capture each input word that a controller puts on a shared, pipelined input bus. The elements are seen as a logical grid `OUT_W` columns wide and `OUT_H` rows high, with element index `p = y*OUT_W + x`. The bus has no addresses. Each word carries a 4-bit command. Every receiver turns that command into an update of its two state flags and passes a rewritten command to its neighbour. In this way the active rectangle grows, shrinks or slides by one column or one row between consecutive words.

Each receiver holds an active flag and a row-marker flag. The active flag means "capture the words that follow". The row-marker flag sits on the column-0 element of each grid row that holds active receivers. The bus is registered once per element, so element `i` acts on a word `i` cycles after element 0 does. A receiver pulses its capture strobe, with the word, when its active flag is set after the word's command has been applied.

A small command generator is built in. Started by a pulse, it walks the input plane in row-major order for window `WIN` and stride `STRIDE`. For each input position it emits the command that leaves exactly the window's receiver set active, and it uses the linear input index as the data word.

Top module: `mcast_rx_chain`

## Requirements
- R1: After reset, every capture strobe, `tail_valid` and `gen_busy` are 0, and all active and row-marker flags are clear.
- R2: A valid word with command 13 (origin) leaves only element 0 active and row-marked, whatever the earlier state, so the word is captured by element 0 alone.
- R3: A head word sampled at clock edge E is registered at element i on edge E+i. If that element is active after the command, `cap[i]` is high for that cycle and `cap_data` slice i holds the word unchanged.
- R4: The column commands affect only the active flags, and each active grid row is treated on its own. Code 1 widens the active columns by one to the right. Code 3 moves them one to the right. Code 2 drops the leftmost active column. An active element in column `OUT_W-1` never activates column 0 of the next row. A receiver that was active forwards code 9, 8 or 10 in place of 1, 3 or 2, respectively.
- R5: The row commands act on the row markers and then reset the active columns to column 0 of each marked row. Code 4 keeps the marked rows. Code 5 adds the row below the last marked row. Code 7 moves the marked rows down by one. Code 6 drops the topmost marked row. Codes 11 and 12 are the carry forms of 5 and 7 that cross from one row to the next.
- R6: Codes 0, 14 and 15 leave both flags unchanged, so the same active set captures the word again, and the command is forwarded unchanged.
- R7: A bus cycle with valid low changes no flag and produces no capture, whatever command and data it carries.
- R8: After a `gen_go` pulse, `gen_busy` is high for exactly `IN_W*IN_H` cycles, where `IN_W = STRIDE*(OUT_W-1)+WIN` and `IN_H` is defined likewise. Input `k = iy*IN_W+ix` is captured by exactly the elements with `ceil((ix-WIN+1)/STRIDE) <= x <= floor(ix/STRIDE)`, clipped to `0..OUT_W-1`, and the matching range in y. This includes strides above one, where consecutive inputs can share a receiver set.
- R9: While `gen_busy` is high, the external inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_valid | input | 1 | External word valid |
| ext_cmd | input | 4 | External command code |
| ext_data | input | DATA_W | External data word |
| gen_go | input | 1 | Start pulse for the built-in generator |
| gen_busy | output | 1 | Generator is driving the bus head |
| cap | output | OUT_W*OUT_H | Per-element capture strobe |
| cap_data | output | OUT_W*OUT_H*DATA_W | Captured word, slice i for element i |
| tail_valid | output | 1 | Valid leaving the last element, for cascading |
| tail_cmd | output | 4 | Rewritten command leaving the last element |
| tail_data | output | DATA_W | Data leaving the last element |

## Verification
The hardest situation to reach from the ports is several different commands in flight at once. In that case a receiver applies a command whose carry was set by a neighbour that has already been changed by a later word. The stimulus therefore sends the column and row commands on back-to-back cycles. It also runs the generator on two instances at once, one with unit stride and one with stride two. Each capture is checked against the exact edge at which it must occur and against an independently computed window set. The row-edge case, where a slide must not leak into the next row, is reached by sliding the active columns into the last column.

// File: rtl/rx_pkg.sv
package rx_pkg;
   typedef enum logic [3:0] {
      RC_IDLE     = 4'd0,
      RC_GROW_X   = 4'd1,
      RC_TRIM_X   = 4'd2,
      RC_STEP_X   = 4'd3,
      RC_WRAP_Y   = 4'd4,
      RC_GROW_Y   = 4'd5,
      RC_TRIM_Y   = 4'd6,
      RC_STEP_Y   = 4'd7,
      RC_STEP_X_C = 4'd8,
      RC_GROW_X_C = 4'd9,
      RC_TRIM_X_C = 4'd10,
      RC_GROW_Y_C = 4'd11,
      RC_STEP_Y_C = 4'd12,
      RC_ORIGIN   = 4'd13,
      RC_RSV_A    = 4'd14,
      RC_RSV_B    = 4'd15
   } rc_cmd_t;

   function automatic rc_cmd_t rc_pick(input logic lo_step, input logic hi_step, input logic y_axis);
      rc_cmd_t r;
      case ({lo_step, hi_step})
         2'b00:   r = y_axis ? RC_WRAP_Y : RC_IDLE;
         2'b01:   r = y_axis ? RC_GROW_Y : RC_GROW_X;
         2'b11:   r = y_axis ? RC_STEP_Y : RC_STEP_X;
         default: r = y_axis ? RC_TRIM_Y : RC_TRIM_X;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/rx_cmd_gen.sv
module rx_cmd_gen
   import rx_pkg::*;
#(
   parameter int OUT_W  = 4,
   parameter int OUT_H  = 3,
   parameter int WIN    = 3,
   parameter int STRIDE = 1,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   output logic              busy,
   output logic [3:0]        o_cmd,
   output logic [DATA_W-1:0] o_data
);
   localparam int IN_W = STRIDE*(OUT_W-1) + WIN;
   localparam int IN_H = STRIDE*(OUT_H-1) + WIN;
   localparam int CW   = $clog2(((IN_W > IN_H) ? IN_W : IN_H) + 1);
   localparam logic [CW-1:0] X_LAST = CW'(IN_W-1);
   localparam logic [CW-1:0] Y_LAST = CW'(IN_H-1);
   localparam logic [CW-1:0] X_QMAX = CW'(OUT_W-1);
   localparam logic [CW-1:0] Y_QMAX = CW'(OUT_H-1);
   localparam logic [CW-1:0] S_M1   = CW'(STRIDE-1);
   localparam logic [CW-1:0] K_MOD  = CW'(WIN % STRIDE);
   localparam logic [CW-1:0] K_VAL  = CW'(WIN);

   logic [CW-1:0] ix, rx, qx, iy, ry, qy;
   logic [DATA_W-1:0] lin;
   logic last_x, last_all;
   logic x_lo, x_hi, y_lo, y_hi;
   rc_cmd_t cmd_c;

   assign last_x   = (ix == X_LAST);
   assign last_all = last_x && (iy == Y_LAST);
   // a range bound moves when the position crosses a stride phase
   assign x_hi = (rx == '0) && (qx <= X_QMAX);
   assign x_lo = (ix >= K_VAL) && (rx == K_MOD);
   assign y_hi = (ry == '0) && (qy <= Y_QMAX);
   assign y_lo = (iy >= K_VAL) && (ry == K_MOD);

   always_comb begin
      if (ix == '0 && iy == '0)  cmd_c = RC_ORIGIN;
      else if (ix == '0)         cmd_c = rc_pick(y_lo, y_hi, 1'b1);
      else                       cmd_c = rc_pick(x_lo, x_hi, 1'b0);
   end

   assign o_cmd  = cmd_c;
   assign o_data = lin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ix <= '0; rx <= '0; qx <= '0;
         iy <= '0; ry <= '0; qy <= '0;
         lin <= '0;
      end else if (!busy) begin
         if (go) begin
            busy <= 1'b1;
            ix <= '0; rx <= '0; qx <= '0;
            iy <= '0; ry <= '0; qy <= '0;
            lin <= '0;
         end
      end else begin
         lin <= lin + 1'b1;
         if (last_all) busy <= 1'b0;
         if (last_x) begin
            ix <= '0; rx <= '0; qx <= '0;
            iy <= iy + 1'b1;
            ry <= (ry == S_M1) ? '0 : ry + 1'b1;
            qy <= qy + CW'(ry == S_M1);
         end else begin
            ix <= ix + 1'b1;
            rx <= (rx == S_M1) ? '0 : rx + 1'b1;
            qx <= qx + CW'(rx == S_M1);
         end
      end
   end

   assert_gen_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(busy) && busy) |-> (o_cmd == 4'd13 && o_data == '0))
      else $error("generator did not open with origin word");
endmodule

// File: rtl/rx_cell.sv
module rx_cell
   import rx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit AT_COL0   = 1'b0,
   parameter bit AT_ORIGIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_vld,
   input  logic [3:0]        i_cmd,
   input  logic [DATA_W-1:0] i_data,
   output logic              o_vld,
   output logic [3:0]        o_cmd,
   output logic [DATA_W-1:0] o_data,
   output logic              cap,
   output logic [DATA_W-1:0] cap_data
);
   rc_cmd_t cmd, fcmd;
   logic rd, ls, nrd, nls, xcar;

   assign cmd  = rc_cmd_t'(i_cmd);
   // column carry never crosses into a new grid row
   assign xcar = !AT_COL0 && (cmd == RC_GROW_X_C || cmd == RC_TRIM_X_C || cmd == RC_STEP_X_C);

   always_comb begin
      nrd  = rd;
      nls  = ls;
      fcmd = cmd;
      if (i_vld) begin
         case (cmd)
            RC_ORIGIN: begin
               nrd = AT_ORIGIN;
               nls = AT_ORIGIN;
            end
            RC_GROW_X, RC_GROW_X_C: begin
               nrd  = rd | xcar;
               fcmd = rd ? RC_GROW_X_C : RC_GROW_X;
            end
            RC_TRIM_X, RC_TRIM_X_C: begin
               nrd  = rd & xcar;
               fcmd = rd ? RC_TRIM_X_C : RC_TRIM_X;
            end
            RC_STEP_X, RC_STEP_X_C: begin
               nrd  = xcar;
               fcmd = rd ? RC_STEP_X_C : RC_STEP_X;
            end
            RC_WRAP_Y, RC_GROW_Y, RC_GROW_Y_C, RC_TRIM_Y, RC_STEP_Y, RC_STEP_Y_C: begin
               if (AT_COL0) begin
                  case (cmd)
                     RC_GROW_Y, RC_GROW_Y_C: begin
                        nls  = ls | (cmd == RC_GROW_Y_C);
                        fcmd = ls ? RC_GROW_Y_C : RC_GROW_Y;
                     end
                     RC_STEP_Y, RC_STEP_Y_C: begin
                        nls  = (cmd == RC_STEP_Y_C);
                        fcmd = ls ? RC_STEP_Y_C : RC_STEP_Y;
                     end
                     RC_TRIM_Y: begin
                        // first marked row is dropped, the rest only wrap
                        nls  = 1'b0;
                        fcmd = ls ? RC_WRAP_Y : RC_TRIM_Y;
                     end
                     default: nls = ls;
                  endcase
                  nrd = nls;
               end else begin
                  nrd = 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd       <= 1'b0;
         ls       <= 1'b0;
         o_vld    <= 1'b0;
         o_cmd    <= 4'd0;
         o_data   <= '0;
         cap      <= 1'b0;
         cap_data <= '0;
      end else begin
         rd     <= nrd;
         ls     <= nls;
         o_vld  <= i_vld;
         o_cmd  <= fcmd;
         o_data <= i_data;
         cap    <= i_vld & nrd;
         if (i_vld & nrd) cap_data <= i_data;
      end
   end

   assert_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(i_vld && i_cmd == 4'd13) |-> (rd == AT_ORIGIN && ls == AT_ORIGIN))
      else $error("origin command left wrong state");

   assert_cap_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cap |-> (o_vld && cap_data == o_data))
      else $error("capture without matching bus word");

   assert_col_keeps_marker_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(i_vld && i_cmd >= 4'd1 && i_cmd <= 4'd3) |-> $stable(ls))
      else $error("column command touched row marker");

   assert_row_resets_cols_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(i_vld && i_cmd >= 4'd4 && i_cmd <= 4'd7) |-> (rd == (AT_COL0 && ls)))
      else $error("row command left active column outside column 0");

   assert_nop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(i_vld && (i_cmd == 4'd0 || i_cmd >= 4'd14)) |->
         ($stable(rd) && $stable(ls) && o_cmd == $past(i_cmd)))
      else $error("no-op changed state or command");

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(i_vld) |-> (!cap && $stable(rd) && $stable(ls)))
      else $error("invalid bus cycle had an effect");
endmodule

// File: rtl/mcast_rx_chain.sv
module mcast_rx_chain
   import rx_pkg::*;
#(
   parameter int OUT_W  = 4,
   parameter int OUT_H  = 3,
   parameter int WIN    = 3,
   parameter int STRIDE = 1,
   parameter int DATA_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ext_valid,
   input  logic [3:0]                ext_cmd,
   input  logic [DATA_W-1:0]         ext_data,
   input  logic                      gen_go,
   output logic                      gen_busy,
   output logic [OUT_W*OUT_H-1:0]    cap,
   output logic [OUT_W*OUT_H*DATA_W-1:0] cap_data,
   output logic                      tail_valid,
   output logic [3:0]                tail_cmd,
   output logic [DATA_W-1:0]         tail_data
);
   localparam int N    = OUT_W*OUT_H;
   localparam int IN_W = STRIDE*(OUT_W-1) + WIN;
   localparam int IN_H = STRIDE*(OUT_H-1) + WIN;

   initial begin
      assert (STRIDE >= 1 && WIN >= STRIDE)
         else $error("window must be at least the stride");
      assert (OUT_W >= 1 && OUT_H >= 1)
         else $error("grid must be non-empty");
      assert (DATA_W >= $clog2(IN_W*IN_H))
         else $error("data width too narrow for the input index");
   end

   logic              g_busy;
   logic [3:0]        g_cmd;
   logic [DATA_W-1:0] g_data;

   rx_cmd_gen #(
      .OUT_W(OUT_W), .OUT_H(OUT_H), .WIN(WIN), .STRIDE(STRIDE), .DATA_W(DATA_W)
   ) u_gen (
      .clk(clk), .rst_n(rst_n), .go(gen_go),
      .busy(g_busy), .o_cmd(g_cmd), .o_data(g_data)
   );

   assign gen_busy = g_busy;

   logic              b_vld [0:N];
   logic [3:0]        b_cmd [0:N];
   logic [DATA_W-1:0] b_dat [0:N];

   assign b_vld[0] = g_busy ? 1'b1   : ext_valid;
   assign b_cmd[0] = g_busy ? g_cmd  : ext_cmd;
   assign b_dat[0] = g_busy ? g_data : ext_data;

   for (genvar i = 0; i < N; i++) begin : g_cell
      rx_cell #(
         .DATA_W   (DATA_W),
         .AT_COL0  ((i % OUT_W) == 0),
         .AT_ORIGIN(i == 0)
      ) u_cell (
         .clk(clk), .rst_n(rst_n),
         .i_vld(b_vld[i]), .i_cmd(b_cmd[i]), .i_data(b_dat[i]),
         .o_vld(b_vld[i+1]), .o_cmd(b_cmd[i+1]), .o_data(b_dat[i+1]),
         .cap(cap[i]), .cap_data(cap_data[i*DATA_W +: DATA_W])
      );
   end

   assign tail_valid = b_vld[N];
   assign tail_cmd   = b_cmd[N];
   assign tail_data  = b_dat[N];
endmodule

// File: tb/tb_mcast_rx_chain.sv
`timescale 1ns/1ps
module tb_mcast_rx_chain;
   localparam int DW = 8;
   localparam int AW = 4, AH = 3, AK = 3, AS = 1;
   localparam int BW = 3, BH = 3, BK = 3, BS = 2;
   localparam int NA = AW*AH, NB = BW*BH;
   localparam int AIW = AS*(AW-1)+AK, AIH = AS*(AH-1)+AK;
   localparam int BIW = BS*(BW-1)+BK, BIH = BS*(BH-1)+BK;

   logic clk = 0, rst_n = 0;
   logic ext_valid = 0, gen_go = 0;
   logic [3:0] ext_cmd = 0;
   logic [DW-1:0] ext_data = 0;
   logic busy_a, busy_b, tv_a, tv_b;
   logic [3:0] tc_a, tc_b;
   logic [DW-1:0] td_a, td_b;
   logic [NA-1:0] cap_a;
   logic [NB-1:0] cap_b;
   logic [NA*DW-1:0] cd_a;
   logic [NB*DW-1:0] cd_b;

   int cyc = 0, checks = 0, errors = 0, busy_cnt_a = 0, busy_cnt_b = 0;
   bit done = 0;
   bit        known_a [256], known_b [256];
   int        send_a [256], send_b [256];
   logic [63:0] exp_a [256], exp_b [256], obs_a [256], obs_b [256];
   string     tag_a [256];
   int        pend_a [$], pend_b [$];

   mcast_rx_chain #(.OUT_W(AW), .OUT_H(AH), .WIN(AK), .STRIDE(AS), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .ext_valid(ext_valid), .ext_cmd(ext_cmd), .ext_data(ext_data),
      .gen_go(gen_go), .gen_busy(busy_a), .cap(cap_a), .cap_data(cd_a),
      .tail_valid(tv_a), .tail_cmd(tc_a), .tail_data(td_a));

   mcast_rx_chain #(.OUT_W(BW), .OUT_H(BH), .WIN(BK), .STRIDE(BS), .DATA_W(DW)) dut_s2 (
      .clk(clk), .rst_n(rst_n), .ext_valid(1'b0), .ext_cmd(4'd0), .ext_data('0),
      .gen_go(gen_go), .gen_busy(busy_b), .cap(cap_b), .cap_data(cd_b),
      .tail_valid(tv_b), .tail_cmd(tc_b), .tail_data(td_b));

   initial forever #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [63:0] win_mask(int ix, int iy, int ow, int oh, int k, int s);
      int xl, xh, yl, yh;
      logic [63:0] m = '0;
      xl = (ix-k+1 <= 0) ? 0 : (ix-k+1+s-1)/s;
      xh = ix/s; if (xh > ow-1) xh = ow-1;
      yl = (iy-k+1 <= 0) ? 0 : (iy-k+1+s-1)/s;
      yh = iy/s; if (yh > oh-1) yh = oh-1;
      for (int y = yl; y <= yh; y++)
         for (int x = xl; x <= xh; x++) m[y*ow+x] = 1'b1;
      return m;
   endfunction

   // monitors: every capture is matched against its word's send edge
   always @(negedge clk) if (rst_n) begin
      for (int i = 0; i < NA; i++) if (cap_a[i]) begin
         int k;
         k = int'(cd_a[i*DW +: DW]);
         checks++;
         if (!known_a[k]) begin
            errors++; $display("FAIL R7 R9 dut elem %0d captured unexpected word %0d (expected none)", i, k);
         end else begin
            if (cyc != send_a[k]+1+i) begin
               errors++; $display("FAIL R3 dut elem %0d word %0d at cycle %0d expected %0d", i, k, cyc, send_a[k]+1+i);
            end
            obs_a[k][i] = 1'b1;
         end
      end
      for (int i = 0; i < NB; i++) if (cap_b[i]) begin
         int k;
         k = int'(cd_b[i*DW +: DW]);
         checks++;
         if (!known_b[k]) begin
            errors++; $display("FAIL R8 dut_s2 elem %0d captured unexpected word %0d (expected none)", i, k);
         end else begin
            if (cyc != send_b[k]+1+i) begin
               errors++; $display("FAIL R3 dut_s2 elem %0d word %0d at cycle %0d expected %0d", i, k, cyc, send_b[k]+1+i);
            end
            obs_b[k][i] = 1'b1;
         end
      end
      if (busy_a) busy_cnt_a++;
      if (busy_b) busy_cnt_b++;
   end

   task automatic send(input logic [3:0] c, input int k, input logic [63:0] m, input string t);
      @(negedge clk);
      ext_valid = 1; ext_cmd = c; ext_data = DW'(k);
      known_a[k] = 1; send_a[k] = cyc; exp_a[k] = m; tag_a[k] = t; obs_a[k] = '0;
      pend_a.push_back(k);
   endtask

   task automatic check(input bit ok, input string t, input int act, input int expv);
      checks++;
      if (!ok) begin errors++; $display("FAIL %s actual %0d expected %0d", t, act, expv); end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      int c0;
      for (int k = 0; k < 256; k++) begin
         known_a[k] = 0; known_b[k] = 0; obs_a[k] = '0; obs_b[k] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (3) begin
         @(negedge clk);
         check(cap_a == '0 && cap_b == '0, "R1 capture strobes after reset", int'(cap_a), 0);
         check(!tv_a && !busy_a && !busy_b, "R1 tail_valid/gen_busy after reset", int'({tv_a, busy_a}), 0);
      end
      // back-to-back external commands, several in flight at once
      send(4'd13, 100, 64'h001, "R2 origin");
      send(4'd1,  101, 64'h003, "R4 widen");
      send(4'd1,  102, 64'h007, "R4 widen");
      send(4'd3,  103, 64'h00E, "R4 slide");
      send(4'd3,  104, 64'h00C, "R4 slide at row edge");
      send(4'd2,  105, 64'h008, "R4 trim");
      send(4'd5,  106, 64'h011, "R5 add row");
      send(4'd1,  107, 64'h033, "R4 widen two rows");
      send(4'd0,  108, 64'h033, "R6 no-op code 0");
      send(4'd15, 109, 64'h033, "R6 reserved code 15");
      @(negedge clk);
      ext_valid = 0; ext_cmd = 4'd13; ext_data = DW'(110);
      repeat (3) @(negedge clk);
      send(4'd0,  111, 64'h033, "R7 state kept over invalid cycles");
      send(4'd7,  112, 64'h110, "R5 move rows down");
      send(4'd6,  113, 64'h100, "R5 drop top row");
      send(4'd1,  114, 64'h300, "R4 widen last row");
      send(4'd4,  115, 64'h100, "R5 wrap to column 0");
      send(4'd13, 116, 64'h001, "R2 origin from busy state");
      @(negedge clk);
      ext_valid = 0; ext_cmd = 0; ext_data = 0;
      repeat (NA+4) @(negedge clk);
      // generator on both instances, external bus driven while busy
      for (int k = 0; k < AIW*AIH; k++) begin
         known_a[k] = 1; exp_a[k] = win_mask(k%AIW, k/AIW, AW, AH, AK, AS);
         tag_a[k] = "R8 generator unit stride"; pend_a.push_back(k);
      end
      for (int k = 0; k < BIW*BIH; k++) begin
         known_b[k] = 1; exp_b[k] = win_mask(k%BIW, k/BIW, BW, BH, BK, BS);
         pend_b.push_back(k);
      end
      busy_cnt_a = 0; busy_cnt_b = 0;
      gen_go = 1; c0 = cyc;
      for (int k = 0; k < AIW*AIH; k++) send_a[k] = c0+1+k;
      for (int k = 0; k < BIW*BIH; k++) send_b[k] = c0+1+k;
      @(negedge clk);
      gen_go = 0;
      ext_valid = 1; ext_cmd = 4'd13; ext_data = DW'(200);
      repeat (6) @(negedge clk);
      ext_valid = 0; ext_cmd = 0; ext_data = 0;
      repeat (BIW*BIH + NB + 10) @(negedge clk);
      check(busy_cnt_a == AIW*AIH, "R8 busy length unit stride", busy_cnt_a, AIW*AIH);
      check(busy_cnt_b == BIW*BIH, "R8 busy length stride two", busy_cnt_b, BIW*BIH);
      while (pend_a.size() > 0) begin
         int k;
         k = pend_a.pop_front();
         checks++;
         if (obs_a[k] != exp_a[k]) begin
            errors++;
            $display("FAIL %s word %0d set actual %0h expected %0h", tag_a[k], k, obs_a[k], exp_a[k]);
         end
      end
      while (pend_b.size() > 0) begin
         int k;
         k = pend_b.pop_front();
         checks++;
         if (obs_b[k] != exp_b[k]) begin
            errors++;
            $display("FAIL R8 generator stride two word %0d set actual %0h expected %0h", k, obs_b[k], exp_b[k]);
         end
      end
      done = 1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
         finish_run();
      end
   end
endmodule